// File: doc/BRIEF.md
# Binary Float Register Widener

The widener takes a floating-point value in one of its memory layouts and turns it into the single 128-bit form that the floating-point register file holds. Whatever the source width, the result has a sign, a 15-bit exponent with bias 16383, and a 112-bit significand whose leading bit is stored explicitly. Because of this, later arithmetic never has to tell the formats apart or rebuild a hidden bit.

A value is presented on `in_word` with a two-bit format code and a one-cycle `in_vld` strobe. The widened value appears on `out_word` one clock later, marked by `out_vld`. Single and double precision values are re-biased. Their subnormals are normalised in the same cycle. Zeros, infinities and NaNs are mapped to fixed encodings. An 80-bit extended value already has the target exponent and an explicit leading bit, so its fields are moved into place unchanged. A value that is already in register form is passed straight through.

Top module: `fpx_expand`

## Requirements
- R1: `out_vld` equals `in_vld` from the previous clock. After reset, `out_vld` is 0 and `out_word` is all zeros.
- R2: When `in_vld` is 0, `out_word` keeps its previous value whatever the other inputs are.
- R3: Format codes:
  - 0 means single precision in `in_word[31:0]`.
  - 1 means double precision in `in_word[63:0]`.
  - 2 means 80-bit extended in `in_word[79:0]`.
  - 3 means register form in all 128 bits.
  - Input bits above the selected format's width have no effect on the result.
- R4: Result layout:
  - bit 127 is the sign;
  - bits 126:112 are the exponent with bias 16383;
  - bit 111 is the explicit leading significand bit;
  - bits 110:0 hold the source fraction left-aligned, with the unused low bits zero.
- R5: A normal single input gives exponent `e+16256`. A normal double input gives `e+15360`. Bit 111 is 1 in both cases.
- R6: A subnormal single or double input is normalised. Its highest set fraction bit becomes bit 111, and the lower fraction bits follow it left-aligned. For a fraction whose highest set bit is at index p, the exponent is `16234+p` for single and `15309+p` for double.
- R7: A single or double zero gives exponent 0 and significand 0, with the sign kept.
- R8: A single or double infinity or NaN gives exponent 0x7FFF, bit 111 set, and the source fraction copied left-aligned below it.
- R9: An extended input places:
  - its sign in bit 127;
  - its 15-bit exponent in bits 126:112;
  - its 64-bit significand, including the explicit bit, in bits 111:48.
  - Bits 47:0 are zero.
- R10: Under format 3 the output equals the input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input value present this cycle |
| in_fmt | input | 2 | Source format code |
| in_word | input | 128 | Source value, right-aligned |
| out_vld | output | 1 | Result present this cycle |
| out_word | output | 128 | Widened register-form value |

## Verification
Two actions can fall in the same cycle: the register captures a new value, and the output presents the previous result. A run of back-to-back valid inputs is interleaved with idle cycles that carry garbage data and format codes. The bench checks every clock against its model. The model must show the last accepted result surviving each idle gap, and each new value landing exactly one cycle after its strobe. Subnormal and special inputs are placed next to normal ones, so a wrong exponent offset or shift shows up at once.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned FPX_WORD_W = 128;
  localparam int unsigned FPX_EXP_W  = 15;
  localparam int unsigned FPX_SIG_W  = FPX_WORD_W - 1 - FPX_EXP_W;

  typedef enum logic [1:0] {
    FMT_SINGLE = 2'd0,
    FMT_DOUBLE = 2'd1,
    FMT_EXT    = 2'd2,
    FMT_RAW    = 2'd3
  } fpx_fmt_e;

  typedef struct packed {
    logic                 sign;
    logic [FPX_EXP_W-1:0] exp;
    logic [FPX_SIG_W-1:0] sig;
  } fpx_reg_t;
endpackage

// File: rtl/fpx_lzc.sv
module fpx_lzc #(
  parameter int unsigned W  = 23,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  d,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < int'(W); i++) begin
      if (d[i]) cnt = CW'(int'(W) - 1 - i);
    end
  end
endmodule

// File: rtl/fpx_widen.sv
module fpx_widen #(
  parameter int unsigned EW     = 8,
  parameter int unsigned FW     = 23,
  parameter int unsigned OUT_EW = 15,
  parameter int unsigned OUT_SW = 112
) (
  input  logic [EW+FW:0]    src,
  output logic              res_sign,
  output logic [OUT_EW-1:0] res_exp,
  output logic [OUT_SW-1:0] res_sig
);
  localparam int unsigned BIAS_IN  = (1 << (EW - 1)) - 1;
  localparam int unsigned BIAS_OUT = (1 << (OUT_EW - 1)) - 1;
  localparam logic [OUT_EW-1:0] OFFSET = OUT_EW'(BIAS_OUT - BIAS_IN);
  localparam int unsigned PAD_W = OUT_SW - 1 - FW;
  localparam int unsigned LZW   = $clog2(FW + 1);

  logic [EW-1:0]  e_fld;
  logic [FW-1:0]  f_fld;
  logic           e_zero, e_ones, f_zero;
  logic [LZW-1:0] lz;
  logic [LZW:0]   sh_amt;
  logic [FW-1:0]  f_norm;

  assign e_fld  = src[EW+FW-1:FW];
  assign f_fld  = src[FW-1:0];
  assign e_zero = (e_fld == '0);
  assign e_ones = (e_fld == '1);
  assign f_zero = (f_fld == '0);

  fpx_lzc #(.W(FW)) u_lzc (.d(f_fld), .cnt(lz));

  assign sh_amt = {1'b0, lz} + {{LZW{1'b0}}, 1'b1};
  assign f_norm = f_fld << sh_amt;

  always_comb begin
    res_sign = src[EW+FW];
    if (e_zero && f_zero) begin
      res_exp = '0;
      res_sig = '0;
    end else if (e_ones) begin
      res_exp = '1;
      res_sig = {1'b1, f_fld, {PAD_W{1'b0}}};
    end else if (e_zero) begin
      res_exp = OFFSET - OUT_EW'(lz);
      res_sig = {1'b1, f_norm, {PAD_W{1'b0}}};
    end else begin
      res_exp = OUT_EW'(e_fld) + OFFSET;
      res_sig = {1'b1, f_fld, {PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fpx_expand.sv
module fpx_expand
  import fpx_pkg::*;
#(
  parameter int unsigned WORD_W = FPX_WORD_W,
  parameter int unsigned EXP_W  = FPX_EXP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [1:0]        in_fmt,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_vld,
  output logic [WORD_W-1:0] out_word
);
  localparam int unsigned SIG_W   = WORD_W - 1 - EXP_W;
  localparam int unsigned EXT_W   = 1 + EXP_W + 64;
  localparam int unsigned EXT_PAD = WORD_W - EXT_W;

  logic              sp_sign, dp_sign;
  logic [EXP_W-1:0]  sp_exp, dp_exp;
  logic [SIG_W-1:0]  sp_sig, dp_sig;
  logic [WORD_W-1:0] word_d, word_q;
  logic              vld_q;
  fpx_fmt_e          fmt;

  assign fmt = fpx_fmt_e'(in_fmt);

  fpx_widen #(.EW(8), .FW(23), .OUT_EW(EXP_W), .OUT_SW(SIG_W)) u_sp (
    .src(in_word[31:0]), .res_sign(sp_sign), .res_exp(sp_exp), .res_sig(sp_sig));

  fpx_widen #(.EW(11), .FW(52), .OUT_EW(EXP_W), .OUT_SW(SIG_W)) u_dp (
    .src(in_word[63:0]), .res_sign(dp_sign), .res_exp(dp_exp), .res_sig(dp_sig));

  always_comb begin
    unique case (fmt)
      FMT_SINGLE: word_d = {sp_sign, sp_exp, sp_sig};
      FMT_DOUBLE: word_d = {dp_sign, dp_exp, dp_sig};
      FMT_EXT:    word_d = {in_word[EXT_W-1:0], {EXT_PAD{1'b0}}};
      default:    word_d = in_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) word_q <= word_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_word = word_q;
endmodule

// File: rtl/fpx_expand_chk.sv
module fpx_expand_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_vld,
  input logic [1:0]   in_fmt,
  input logic [127:0] in_word,
  input logic         out_vld,
  input logic [127:0] out_word
);
  AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> out_vld); // R1
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> !out_vld); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> $stable(out_word)); // R2
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_fmt == 2'd3) |=> out_word == $past(in_word)); // R10
  AST_EXT_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_fmt == 2'd2) |=> out_word[47:0] == '0); // R9
  AST_SP_LEAD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_fmt == 2'd0 && in_word[30:0] != '0) |=> out_word[111]); // R6
  AST_DP_LEAD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_fmt == 2'd1 && in_word[62:0] != '0) |=> out_word[111]); // R5
  AST_SP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_fmt == 2'd0 && in_word[30:0] == '0) |=> out_word[126:0] == '0); // R7
  AST_SP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_fmt == 2'd0) |=> out_word[127] == $past(in_word[31])); // R4
endmodule

bind fpx_expand fpx_expand_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_fmt(in_fmt),
  .in_word(in_word), .out_vld(out_vld), .out_word(out_word));

// File: tb/sim_fpx_expand.sv
`timescale 1ns/1ps
module sim_fpx_expand;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [1:0]   in_fmt = 2'd0;
  logic [127:0] in_word = '0;
  logic         out_vld;
  logic [127:0] out_word;

  int checks = 0;
  int errors = 0;
  logic         exp_vld = 1'b0;
  logic [127:0] exp_word = '0;
  string        exp_tag = "R1";
  bit           done = 1'b0;

  always #5 clk = ~clk;

  fpx_expand u0 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_fmt(in_fmt),
                 .in_word(in_word), .out_vld(out_vld), .out_word(out_word));

  function automatic logic [127:0] ieee_model(input logic s, input int e, input logic [63:0] f,
                                              input int ew, input int fw, output string tag);
    int emax, bias, p;
    logic [111:0] sig;
    logic [14:0]  ex;
    emax = (1 << ew) - 1;
    bias = (1 << (ew - 1)) - 1;
    if (e == 0 && f == 0) begin
      tag = "R7";
      return {s, 127'b0};
    end
    if (e == emax) begin
      tag = "R8";
      sig = {1'b1, 111'b0} | ({48'b0, f} << (111 - fw));
      return {s, 15'h7FFF, sig};
    end
    if (e == 0) begin
      tag = "R6";
      p = 0;
      for (int i = 0; i < fw; i++) if (f[i]) p = i;
      ex = 15'(p - (bias - 1 + fw) + 16383);
      sig = {48'b0, f} << (111 - p);
      return {s, ex, sig};
    end
    tag = "R5";
    ex = 15'(e - bias + 16383);
    sig = {1'b1, 111'b0} | ({48'b0, f} << (111 - fw));
    return {s, ex, sig};
  endfunction

  function automatic logic [127:0] model(input logic [1:0] fmt, input logic [127:0] w,
                                         output string tag);
    case (fmt)
      2'd0: return ieee_model(w[31], int'(w[30:23]), {41'b0, w[22:0]}, 8, 23, tag);
      2'd1: return ieee_model(w[63], int'(w[62:52]), {12'b0, w[51:0]}, 11, 52, tag);
      2'd2: begin tag = "R9"; return {w[79:0], 48'b0}; end
      default: begin tag = "R10"; return w; end
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (out_vld !== exp_vld) begin
      errors++;
      $display("FAIL R1 out_vld actual %0b expected %0b", out_vld, exp_vld);
    end
    checks++;
    if (out_word !== exp_word) begin
      errors++;
      $display("FAIL %s out_word actual %h expected %h", exp_tag, out_word, exp_word);
    end
  endtask

  // Drive one cycle; use_lit selects a hand-computed expectation.
  task automatic step(input logic v, input logic [1:0] fmt, input logic [127:0] w,
                      input bit use_lit, input logic [127:0] lit, input string lit_tag);
    string t;
    logic [127:0] m;
    @(negedge clk);
    compare();
    in_vld = v; in_fmt = fmt; in_word = w;
    m = model(fmt, w, t);
    exp_vld = v;
    if (v) begin
      exp_word = use_lit ? lit : m;
      exp_tag  = use_lit ? lit_tag : t;
    end else begin
      exp_tag = "R2";
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] w;
    repeat (3) @(negedge clk);
    compare(); // R1 reset state: out_vld 0, out_word 0
    @(negedge clk);
    rst_n = 1'b1;
    // R4 R5: single 1.0
    step(1, 2'd0, 128'h3F80_0000, 1, 128'h3FFF_8000_0000_0000_0000_0000_0000_0000, "R5");
    // R3: garbage above the single field has no effect
    step(1, 2'd0, {96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'h3F80_0000}, 1,
         128'h3FFF_8000_0000_0000_0000_0000_0000_0000, "R3");
    // R6: smallest single subnormal, p=0
    step(1, 2'd0, 128'h0000_0001, 1, 128'h3F6A_8000_0000_0000_0000_0000_0000_0000, "R6");
    // R6: single subnormal with p=22
    step(1, 2'd0, 128'h0040_0000, 1, 128'h3F80_8000_0000_0000_0000_0000_0000_0000, "R6");
    // R5: double -2.0
    step(1, 2'd1, 128'hC000_0000_0000_0000, 1, 128'hC000_8000_0000_0000_0000_0000_0000_0000, "R5");
    // R2: idle cycles with garbage inputs
    step(0, 2'd3, {4{32'hA5A5_5A5A}}, 0, '0, "R2");
    step(0, 2'd1, {4{32'h1234_5678}}, 0, '0, "R2");
    // R8: single minus infinity and quiet NaN
    step(1, 2'd0, 128'hFF80_0000, 1, 128'hFFFF_8000_0000_0000_0000_0000_0000_0000, "R8");
    step(1, 2'd0, 128'h7FC0_0000, 1, 128'h7FFF_C000_0000_0000_0000_0000_0000_0000, "R8");
    // R7: double minus zero
    step(1, 2'd1, 128'h8000_0000_0000_0000, 1, 128'h8000_0000_0000_0000_0000_0000_0000_0000, "R7");
    // R9: extended 1.0 with garbage above bit 79 (R3)
    step(1, 2'd2, {48'hFFFF_FFFF_FFFF, 80'h3FFF_8000_0000_0000_0000}, 1,
         128'h3FFF_8000_0000_0000_0000_0000_0000_0000, "R9");
    // R10: raw passthrough
    step(1, 2'd3, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1,
         128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R10");
    // Mixed random traffic, judged against the behavioural model
    for (int n = 0; n < 1200; n++) begin
      int kind;
      logic [1:0] f;
      logic v;
      w = {$urandom, $urandom, $urandom, $urandom};
      f = 2'($urandom % 4);
      kind = $urandom % 5;
      v = ($urandom % 4) != 0;
      if (f == 2'd0) begin
        if (kind == 1) w[30:23] = '0;
        if (kind == 2) w[30:23] = '1;
        if (kind == 3) w[30:0] = '0;
        if (kind == 4) begin w[30:23] = '0; w[22:0] = 23'(1) << ($urandom % 23); end
      end else if (f == 2'd1) begin
        if (kind == 1) w[62:52] = '0;
        if (kind == 2) w[62:52] = '1;
        if (kind == 3) w[62:0] = '0;
        if (kind == 4) begin w[62:52] = '0; w[51:0] = 52'(1) << ($urandom % 52); end
      end
      step(v, f, w, 0, '0, "");
    end
    step(0, 2'd0, '0, 0, '0, "R2");
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule